// File: doc/BRIEF.md
# Seven-Port Handshaked Crossbar Switch

This block joins seven input ports to seven output ports. Every output owns a select register that names the input feeding it. The output then carries that input's 8-bit byte and its strobe. The acknowledge raised on the output travels back through the same mapping to the input it selected. Several outputs may draw on one input, and that input then sees the OR of their acknowledges. All sharing is built from multiplexers and AND-OR logic. The design has no high-impedance values.

A simple write port loads the configuration: an output index, a source index and an enable bit. A new mapping takes hold at the next clock edge, so a mapping can change on every transfer. Each output runs a small state machine that tracks the handshake in progress. A write that arrives while a strobe is waiting for its acknowledge is refused. The refusal is flagged by a one-cycle error pulse.

Per-output states:
- SLOT_OFF: the output is disabled or disconnected.
- SLOT_IDLE: the output is connected and has no strobe pending.
- SLOT_WAIT: a strobe has been seen and its acknowledge has not yet returned.

Transitions:
- OFF to IDLE: an accepted write with enable set and a source below 7.
- IDLE to WAIT: the output strobe is high while its acknowledge is low.
- WAIT to IDLE: the acknowledge arrives.
- IDLE to OFF: an accepted write that clears enable or selects 7.
- IDLE to IDLE: an accepted write to another valid source.

Top module: `hsx_crossbar`

## Requirements
- R1: While output j is enabled with select s < 7, out_data[8j+7:8j] equals in_data[8s+7:8s] and out_stb[j] equals in_stb[s] in the same cycle.
- R2: While output j is disabled, or its select is 7 (disconnected), its data and strobe are zero and its out_ack[j] reaches no input.
- R3: in_ack[i] is the OR of out_ack[j] over every connected output j whose select equals i.
- R4: A write (cfg_we=1, cfg_port=j<7, cfg_sel, cfg_en) takes effect at the next rising edge. Writes on back-to-back cycles each apply in turn.
- R5: A write to output j is refused when, in the write cycle, output j is in SLOT_WAIT or has out_stb[j]=1 with out_ack[j]=0. A refused write leaves the select and enable unchanged and raises cfg_err for exactly the following cycle. An accepted write leaves cfg_err low.
- R6: A write with cfg_port=7 changes nothing and raises no error.
- R7: Reset (rst_n=0) disables every output, sets every select to 7 and clears cfg_err. Data, strobe and acknowledge outputs are then all zero.
- R8: Several outputs may select the same input at once, and each of them receives that input's byte and strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 56 | Input bytes, port i at bits 8i+7:8i |
| in_stb | input | 7 | Input strobes, bit i for port i |
| in_ack | output | 7 | Acknowledge returned to each input |
| out_data | output | 56 | Output bytes, port j at bits 8j+7:8j |
| out_stb | output | 7 | Output strobes |
| out_ack | input | 7 | Acknowledge from each output's sink |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_port | input | 3 | Output index being written, 7 ignored |
| cfg_sel | input | 3 | Source input index, 7 means disconnected |
| cfg_en | input | 1 | Enable bit for the output |
| cfg_err | output | 1 | One-cycle pulse after a refused write |

## Verification
The bench loads two outputs from the same input. A design that decoded only one match would starve the second output. It checks the acknowledge OR against an acknowledge pattern that is asserted on only one output. A design that ignored the select during acknowledge routing would light extra inputs. It also checks that an output that is disabled but still selecting a strobing input sends no acknowledge back.

The bench writes an output while its strobe waits for an acknowledge and expects the select to hold with a single error pulse. It then repeats the write after the acknowledge and expects it to land. A design that fails to track the pending strobe would either switch mid-transfer or refuse the write forever. Back-to-back writes, a write to index 7 and a reset during traffic expose select registers that load late, decode the spare index, or keep state across reset.

// File: rtl/hsx_pkg.sv
package hsx_pkg;
    typedef enum logic [1:0] {
        SLOT_OFF  = 2'd0,
        SLOT_IDLE = 2'd1,
        SLOT_WAIT = 2'd2
    } slot_state_t;
endpackage

// File: rtl/hsx_slot.sv
module hsx_slot
    import hsx_pkg::*;
#(
    parameter int NP = 7,
    parameter int SW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [SW-1:0] wr_sel,
    input  logic          wr_en,
    input  logic          stb,
    input  logic          ack,
    output logic [SW-1:0] sel,
    output logic          active,
    output logic          reject
);
    localparam logic [SW-1:0] DISC = SW'(NP);

    slot_state_t state_q, state_d;
    logic [SW-1:0] sel_q, sel_d;
    logic pending, accept, connect;

    assign pending = (state_q == SLOT_WAIT) || (stb && !ack);
    assign accept  = wr && !pending;
    assign reject  = wr && pending;
    assign connect = wr_en && (wr_sel < DISC);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_OFF;
            sel_q   <= DISC;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
        end
    end

    always_comb begin
        state_d = state_q;
        sel_d   = accept ? wr_sel : sel_q;
        unique case (state_q)
            SLOT_OFF: begin
                if (accept && connect) state_d = SLOT_IDLE;
            end
            SLOT_IDLE: begin
                if (accept)            state_d = connect ? SLOT_IDLE : SLOT_OFF;
                else if (stb && !ack)  state_d = SLOT_WAIT;
            end
            SLOT_WAIT: begin
                if (ack)               state_d = SLOT_IDLE;
            end
            default:                   state_d = SLOT_OFF;
        endcase
    end

    assign sel    = sel_q;
    assign active = (state_q != SLOT_OFF);
endmodule

// File: rtl/hsx_fwd_mux.sv
module hsx_fwd_mux #(
    parameter int NP = 7,
    parameter int DW = 8,
    parameter int SW = 3
) (
    input  logic [NP*DW-1:0] in_data,
    input  logic [NP-1:0]    in_stb,
    input  logic [SW-1:0]    sel,
    input  logic             active,
    output logic [DW-1:0]    data,
    output logic             stb
);
    always_comb begin
        data = '0;
        stb  = 1'b0;
        for (int i = 0; i < NP; i++) begin
            if (active && sel == SW'(i)) begin
                data = data | in_data[i*DW +: DW];
                stb  = stb | in_stb[i];
            end
        end
    end
endmodule

// File: rtl/hsx_ack_route.sv
module hsx_ack_route #(
    parameter int NP = 7,
    parameter int SW = 3
) (
    input  logic [NP*SW-1:0] sel_flat,
    input  logic [NP-1:0]    active,
    input  logic [NP-1:0]    out_ack,
    output logic [NP-1:0]    in_ack
);
    always_comb begin
        in_ack = '0;
        for (int i = 0; i < NP; i++) begin
            for (int j = 0; j < NP; j++) begin
                if (active[j] && out_ack[j] && sel_flat[j*SW +: SW] == SW'(i))
                    in_ack[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/hsx_crossbar.sv
module hsx_crossbar #(
    parameter int NP = 7,
    parameter int DW = 8,
    parameter int SW = $clog2(NP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NP*DW-1:0] in_data,
    input  logic [NP-1:0]    in_stb,
    output logic [NP-1:0]    in_ack,
    output logic [NP*DW-1:0] out_data,
    output logic [NP-1:0]    out_stb,
    input  logic [NP-1:0]    out_ack,
    input  logic             cfg_we,
    input  logic [SW-1:0]    cfg_port,
    input  logic [SW-1:0]    cfg_sel,
    input  logic             cfg_en,
    output logic             cfg_err
);
    logic [NP*SW-1:0] sel_flat;
    logic [NP-1:0]    active;
    logic [NP-1:0]    reject;

    for (genvar j = 0; j < NP; j++) begin : g_out
        logic [SW-1:0] sel_j;
        logic          wr_j;

        assign wr_j = cfg_we && (cfg_port == SW'(j));

        hsx_slot #(.NP(NP), .SW(SW)) slot_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (wr_j),
            .wr_sel (cfg_sel),
            .wr_en  (cfg_en),
            .stb    (out_stb[j]),
            .ack    (out_ack[j]),
            .sel    (sel_j),
            .active (active[j]),
            .reject (reject[j])
        );

        assign sel_flat[j*SW +: SW] = sel_j;

        hsx_fwd_mux #(.NP(NP), .DW(DW), .SW(SW)) mux_i (
            .in_data (in_data),
            .in_stb  (in_stb),
            .sel     (sel_j),
            .active  (active[j]),
            .data    (out_data[j*DW +: DW]),
            .stb     (out_stb[j])
        );
    end

    hsx_ack_route #(.NP(NP), .SW(SW)) ack_i (
        .sel_flat (sel_flat),
        .active   (active),
        .out_ack  (out_ack),
        .in_ack   (in_ack)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_err <= 1'b0;
        else        cfg_err <= |reject;
    end
endmodule

// File: rtl/hsx_crossbar_chk.sv
module hsx_crossbar_chk #(
    parameter int NP = 7,
    parameter int DW = 8,
    parameter int SW = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NP-1:0]    in_stb,
    input logic [NP-1:0]    in_ack,
    input logic [NP*DW-1:0] out_data,
    input logic [NP-1:0]    out_stb,
    input logic [NP-1:0]    out_ack,
    input logic [NP-1:0]    active,
    input logic [NP*SW-1:0] sel_flat,
    input logic             cfg_we,
    input logic             cfg_err
);
    for (genvar j = 0; j < NP; j++) begin : g_chk
        assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !active[j] |-> (out_stb[j] == 1'b0 && out_data[j*DW +: DW] == '0));
    end

    assert_ack_needs_sink_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|in_ack) |-> (|out_ack));

    assert_stb_needs_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_stb) |-> (|in_stb));

    assert_err_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(cfg_we));

    assert_err_keeps_map_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $stable(sel_flat));
endmodule

bind hsx_crossbar hsx_crossbar_chk #(.NP(NP), .DW(DW), .SW(SW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_stb   (in_stb),
    .in_ack   (in_ack),
    .out_data (out_data),
    .out_stb  (out_stb),
    .out_ack  (out_ack),
    .active   (active),
    .sel_flat (sel_flat),
    .cfg_we   (cfg_we),
    .cfg_err  (cfg_err)
);

// File: tb/hsx_crossbar_tb_top.sv
`timescale 1ns/1ps
module hsx_crossbar_tb_top;
    localparam int NP = 7;
    localparam int DW = 8;
    localparam int SW = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NP*DW-1:0] in_data = '0;
    logic [NP-1:0]    in_stb = '0;
    logic [NP-1:0]    in_ack;
    logic [NP*DW-1:0] out_data;
    logic [NP-1:0]    out_stb;
    logic [NP-1:0]    out_ack = '0;
    logic             cfg_we = 1'b0;
    logic [SW-1:0]    cfg_port = '0;
    logic [SW-1:0]    cfg_sel = '0;
    logic             cfg_en = 1'b0;
    logic             cfg_err;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    hsx_crossbar #(.NP(NP), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_stb(in_stb),
        .in_ack(in_ack), .out_data(out_data), .out_stb(out_stb),
        .out_ack(out_ack), .cfg_we(cfg_we), .cfg_port(cfg_port),
        .cfg_sel(cfg_sel), .cfg_en(cfg_en), .cfg_err(cfg_err)
    );

    // {port[3], sel[3], en, exp_data[8], exp_stb}
    localparam int NV = 7;
    localparam bit [15:0] VEC [NV] = '{
        {3'd0, 3'd3, 1'b1, 8'h33, 1'b0},
        {3'd1, 3'd0, 1'b1, 8'h30, 1'b1},
        {3'd2, 3'd6, 1'b1, 8'h36, 1'b1},
        {3'd3, 3'd3, 1'b1, 8'h33, 1'b0},
        {3'd4, 3'd7, 1'b1, 8'h00, 1'b0},
        {3'd5, 3'd2, 1'b0, 8'h00, 1'b0},
        {3'd6, 3'd4, 1'b1, 8'h34, 1'b1}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] p, input logic [2:0] s, input logic e);
        @(negedge clk);
        cfg_we = 1'b1; cfg_port = p; cfg_sel = s; cfg_en = e;
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
    endtask

    function automatic logic [8:0] port_of(input int j);
        return {out_data[j*DW +: DW], out_stb[j]};
    endfunction

    initial begin
        #1_000_000;
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NP; i++) in_data[i*DW +: DW] = 8'h30 + 8'(i);
        in_stb = 7'b1010101;
        repeat (3) @(negedge clk);
        #1;
        // R7 reset state
        check("R7 data", 64'(out_data), 64'h0);
        check("R7 stb/ack/err", 64'({out_stb, in_ack, cfg_err}), 64'h0);
        @(negedge clk); rst_n = 1'b1;

        out_ack = 7'h7F;
        for (int v = 0; v < NV; v++) begin
            cfg_write(VEC[v][15:13], VEC[v][12:10], VEC[v][9]);
            // R1 R2 R4 R8
            check("R1/R2/R4/R8 vector", 64'(port_of(int'(VEC[v][15:13]))), 64'(VEC[v][8:0]));
            check("R5 no err on accept", 64'(cfg_err), 64'h0);
        end
        // R3: sources 0,3,4,6 selected by live outputs; 2 only by disabled one
        check("R3 ack fan-in", 64'(in_ack), 64'h59);
        // R8: outputs 0 and 3 share input 3
        check("R8 shared", 64'({port_of(0), port_of(3)}), 64'({9'h066, 9'h066}));

        @(negedge clk); out_ack = 7'b0000001; #1;
        check("R3 select-gated ack", 64'(in_ack), 64'h08);
        @(negedge clk); out_ack = 7'b0010000; #1;
        check("R2 disc ack dropped", 64'(in_ack), 64'h00);
        @(negedge clk); out_ack = 7'b0100000; #1;
        check("R2 disabled ack dropped", 64'(in_ack), 64'h00);

        // R5: out 1 strobing from input 0 with no ack
        @(negedge clk); out_ack = 7'b0000000;
        cfg_write(3'd1, 3'd5, 1'b1);
        check("R5 err pulse", 64'(cfg_err), 64'h1);
        check("R5 map kept", 64'(port_of(1)), 64'h061);
        @(negedge clk); #1;
        check("R5 err single", 64'(cfg_err), 64'h0);
        @(negedge clk); out_ack = 7'h7F;
        @(negedge clk);
        cfg_write(3'd1, 3'd5, 1'b1);
        check("R5 accepted after ack", 64'({cfg_err, port_of(1)}), 64'({1'b0, 9'h06A}));

        // R4: back-to-back writes to output 0
        @(negedge clk);
        cfg_we = 1'b1; cfg_port = 3'd0; cfg_sel = 3'd1; cfg_en = 1'b1;
        @(negedge clk); #1;
        check("R4 first write", 64'(port_of(0)), 64'h062);
        cfg_sel = 3'd2;
        @(negedge clk); cfg_we = 1'b0; #1;
        check("R4 second write", 64'(port_of(0)), 64'h065);

        // R6: index 7 ignored
        begin
            logic [NP*DW-1:0] snap;
            snap = out_data;
            cfg_write(3'd7, 3'd0, 1'b0);
            check("R6 no err", 64'(cfg_err), 64'h0);
            check("R6 unchanged", 64'(out_data), 64'(snap));
        end

        // R2 disable by write
        cfg_write(3'd6, 3'd4, 1'b0);
        check("R2 disabled by write", 64'(port_of(6)), 64'h0);

        // R7 reset during traffic
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); #1;
        check("R7 reset clears", 64'({out_data, out_stb, in_ack, cfg_err}), 64'h0);
        rst_n = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule